// File: doc/BRIEF.md
# Multi-Channel GPIO Interrupt Controller

This block collects interrupt requests from 64 general-purpose pad inputs. The inputs are handled as two banks of 32. Each input has four settings. It can be edge-sensitive or level-sensitive. Its polarity selects the rising edge or high level when set, and the falling edge or low level when clear. In edge mode a separate bit makes it react to both transitions. An enable bit lets the input reach the interrupt line. Edges are latched in a status word, and software clears each status bit by writing 1 to it.

Each pad passes through a two-stage synchronizer, and edges are found by comparing the synchronized value with the sample from the cycle before. The status ANDed with the enable gives the masked status. The OR of all masked bits drives one interrupt line, and a global enable bit gates that line. Software uses a single-cycle synchronous write port and a combinational read port, each addressed by 32-bit word.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, all enable, type, polarity, both-edge and global-enable words read 0, every masked-status word reads 0, and `irq` is 0.
- R2: A word address is kind*2 + bank, where bank 0 covers inputs 0..31 and bank 1 covers inputs 32..63. The kinds are: 0 enable, 1 type (1 = edge), 2 polarity (1 = rising/high), 3 both-edge, 4 clear (write-only), 5 status, 6 masked status, and 7 global enable (bit 0, bank 0 only). The configuration words read back what was written.
- R3: An edge-mode input with both-edge clear latches status bit 1 on a rising synchronized edge when polarity is 1, or on a falling edge when polarity is 0. The opposite edge, or no change, leaves the bit at 0.
- R4: An edge-mode input with both-edge set latches status on either transition, whatever its polarity.
- R5: A level-mode input's status bit follows the synchronized pad: it equals the pad value when polarity is 1 and its inverse when polarity is 0. It is not latched, and writes to the clear word do not change it.
- R6: Writing 1 to a bit of the clear word clears that latched edge status bit. Bits written as 0 keep their value.
- R7: If an edge is detected on an input in the same cycle as a clear of that input's bit, the bit stays 1.
- R8: The masked-status word equals status AND enable. `irq` is 1 exactly when the global enable is 1 and some masked-status bit is 1.
- R9: While the global enable is 0, no edge status is latched.
- R10: A pad change driven before clock edge N shows in edge status after clock edge N+2, and not after edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 4 | Word address (kind*2 + bank) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 64 | Asynchronous pad inputs |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can act on the same status bit in one cycle: a software clear of that bit and a newly detected edge on the same input. The bench provokes this by latching a bit in both-edge mode and toggling the pad. It then times a clear write so that it lands on the clock edge where the synchronized edge is detected, two clock edges after the pad change. The bit must still read 1 afterwards. A plain clear then shows that the bit was really cleared and was not stuck.

// File: rtl/gpio_irq_pkg.sv
// Package: shared sizes and register kinds of the GPIO interrupt controller.
// Assumes: the input count is a multiple of the word width, with at least two words.
package gpio_irq_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_ENABLE  = 3'd0,
        K_TYPE    = 3'd1,
        K_POL     = 3'd2,
        K_BOTH    = 3'd3,
        K_CLEAR   = 3'd4,
        K_STATUS  = 3'd5,
        K_MASKED  = 3'd6,
        K_GLOBAL  = 3'd7
    } reg_kind_e;

endpackage

// File: rtl/gpio_irq_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pad inputs.
// Assumes: each bit is independent; the reset value of every stage is 0.
module gpio_irq_sync #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First flop captures the raw pad value.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each further flop resamples the stage before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end

            // R10: each stage holds what the previous stage had one cycle earlier.
            a_r10_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
                stage_q[s] == $past(stage_q[s-1]));
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_bank.sv
// Module: configuration and status for one word of inputs.
// Holds enable, type, polarity and both-edge bits, detects edges against the
// previous synchronized sample, latches edge status with write-one-to-clear,
// and forms the level and masked status.
// Assumes: sync_in is already synchronized; the write strobes are one-hot.
module gpio_irq_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         glb_en,
    input  logic [W-1:0] sync_in,
    input  logic         wr_en_ie,
    input  logic         wr_type,
    input  logic         wr_pol,
    input  logic         wr_both,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ie_o,
    output logic [W-1:0] type_o,
    output logic [W-1:0] pol_o,
    output logic [W-1:0] both_o,
    output logic [W-1:0] status_o,
    output logic [W-1:0] masked_o
);

    logic [W-1:0] ie_q, type_q, pol_q, both_q;
    logic [W-1:0] prev_q, edge_q;
    logic [W-1:0] rise, fall, evt, clr_mask, level;

    // Configuration words, each written by its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= '0;
            type_q <= '0;
            pol_q  <= '0;
            both_q <= '0;
        end else begin
            if (wr_en_ie) ie_q   <= wdata;
            if (wr_type)  type_q <= wdata;
            if (wr_pol)   pol_q  <= wdata;
            if (wr_both)  both_q <= wdata;
        end
    end

    // Previous synchronized sample, the reference for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    // Edge events qualified by mode, polarity, both-edge and global enable.
    always_comb begin
        rise     = sync_in & ~prev_q;
        fall     = ~sync_in & prev_q;
        evt      = {W{glb_en}} & type_q &
                   ((both_q & (rise | fall)) |
                    (~both_q & pol_q & rise) |
                    (~both_q & ~pol_q & fall));
        clr_mask = wr_clr ? wdata : '0;
        level    = ~(sync_in ^ pol_q);
    end

    // Latched edge status: clear by writing 1, a new edge wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= (edge_q & ~clr_mask) | evt;
    end

    // Read-side status: latched for edge inputs, live for level inputs.
    always_comb begin
        status_o = (type_q & edge_q) | (~type_q & level);
        masked_o = status_o & ie_q;
    end

    assign ie_o   = ie_q;
    assign type_o = type_q;
    assign pol_o  = pol_q;
    assign both_o = both_q;

    // R6: bits written 1 to clear with no fresh edge end up 0.
    a_r6_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((edge_q & $past(wdata & ~evt)) == '0));

    // R6: bits written 0 to clear keep a set value.
    a_r6_clear_zeros_keep: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((edge_q & $past(edge_q & ~wdata)) == $past(edge_q & ~wdata)));

    // R7: a detected edge always leaves its bit set, even against a clear.
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((edge_q & $past(evt)) == $past(evt)));

    // R3: a status bit never rises without a detected edge.
    a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((edge_q & ~$past(edge_q) & ~$past(evt)) == '0));

    // R9: with the global enable off, no status bit rises.
    a_r9_disabled_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> ((edge_q & ~$past(edge_q)) == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: top of the GPIO interrupt controller.
// Decodes the word address into a register kind and a bank, instantiates one
// bank per word, holds the global enable, muxes read data and combines the
// masked status into one interrupt line.
// Assumes: NUM_INPUTS / WORD_W is a power of two and at least 2.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_INPUTS  = 64,
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_WORDS  = NUM_INPUTS / WORD_W,
    localparam int BANK_BITS  = $clog2(NUM_WORDS),
    localparam int ADDR_W     = KIND_W + BANK_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    input  logic [NUM_INPUTS-1:0] pad_in,
    output logic                  irq
);

    logic [KIND_W-1:0]    kind;
    logic [BANK_BITS-1:0] bank;
    logic [NUM_INPUTS-1:0] pad_sync;
    logic                 glb_q;
    logic                 any_pending;

    logic [WORD_W-1:0] ie_w     [NUM_WORDS];
    logic [WORD_W-1:0] type_w   [NUM_WORDS];
    logic [WORD_W-1:0] pol_w    [NUM_WORDS];
    logic [WORD_W-1:0] both_w   [NUM_WORDS];
    logic [WORD_W-1:0] status_w [NUM_WORDS];
    logic [WORD_W-1:0] masked_w [NUM_WORDS];

    assign kind = bus_addr[ADDR_W-1:BANK_BITS];
    assign bank = bus_addr[BANK_BITS-1:0];

    gpio_irq_sync #(
        .WIDTH  (NUM_INPUTS),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    // Global enable bit, bit 0 of the bank-0 global word.
    always_ff @(posedge clk) begin
        if (!rst_n) glb_q <= 1'b0;
        else if (bus_wr && kind == K_GLOBAL && bank == '0) glb_q <= bus_wdata[0];
    end

    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_bank
            logic sel;
            assign sel = bus_wr && (bank == BANK_BITS'(w));

            gpio_irq_bank #(
                .W (WORD_W)
            ) i_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .glb_en   (glb_q),
                .sync_in  (pad_sync[w*WORD_W +: WORD_W]),
                .wr_en_ie (sel && kind == K_ENABLE),
                .wr_type  (sel && kind == K_TYPE),
                .wr_pol   (sel && kind == K_POL),
                .wr_both  (sel && kind == K_BOTH),
                .wr_clr   (sel && kind == K_CLEAR),
                .wdata    (bus_wdata),
                .ie_o     (ie_w[w]),
                .type_o   (type_w[w]),
                .pol_o    (pol_w[w]),
                .both_o   (both_w[w]),
                .status_o (status_w[w]),
                .masked_o (masked_w[w])
            );
        end
    endgenerate

    // Read data mux over register kind and bank.
    always_comb begin
        case (reg_kind_e'(kind))
            K_ENABLE: bus_rdata = ie_w[bank];
            K_TYPE:   bus_rdata = type_w[bank];
            K_POL:    bus_rdata = pol_w[bank];
            K_BOTH:   bus_rdata = both_w[bank];
            K_STATUS: bus_rdata = status_w[bank];
            K_MASKED: bus_rdata = masked_w[bank];
            K_GLOBAL: bus_rdata = (bank == '0) ? {{(WORD_W-1){1'b0}}, glb_q} : '0;
            default:  bus_rdata = '0;
        endcase
    end

    // OR of every masked status bit across all banks.
    always_comb begin
        any_pending = 1'b0;
        for (int w = 0; w < NUM_WORDS; w++) any_pending = any_pending | (|masked_w[w]);
    end

    assign irq = glb_q & any_pending;

    // R1: the global enable comes out of reset cleared.
    a_r1_global_reset: assert property (@(posedge clk)
        !rst_n |=> !glb_q);

    // R8: the interrupt line stays low one cycle after the global enable was written 0.
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && kind == K_GLOBAL && bank == '0 && !bus_wdata[0]) |=> !irq);

endmodule

// File: tb/test_gpio_irq_ctrl.sv
// Bench for gpio_irq_ctrl: a table of single-input scenarios walked by one
// loop, then directed checks for reset, latency, gating and clear races.
module test_gpio_irq_ctrl;

    localparam int N  = 64;
    localparam int DW = 32;

    // Word kinds; address = kind*2 + bank.
    localparam int KE = 0, KT = 1, KP = 2, KB = 3, KC = 4, KS = 5, KM = 6, KG = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] rd;

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .irq       (irq)
    );

    always #10 clk = ~clk;

    // Scenario vectors: {type, pol, both, v0, v1, expected status}.
    localparam int NV = 11;
    localparam logic [5:0] VEC [NV] = '{
        6'b110_01_1,  // R3 rising edge latched
        6'b110_10_0,  // R3 falling edge ignored in rising mode
        6'b100_10_1,  // R3 falling edge latched
        6'b100_01_0,  // R3 rising edge ignored in falling mode
        6'b101_01_1,  // R4 both edges, rise, pol 0
        6'b111_10_1,  // R4 both edges, fall, pol 1
        6'b110_11_0,  // R3 no change, nothing latched
        6'b010_01_1,  // R5 level high, pad 1
        6'b010_10_0,  // R5 level high, pad 0
        6'b000_10_1,  // R5 level low, pad 0
        6'b000_01_0   // R5 level low, pad 1
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int kind, input int bank, input logic [DW-1:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(kind*2 + bank); bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int kind, input int bank, output logic [DW-1:0] data);
        @(negedge clk);
        bus_addr = 4'(kind*2 + bank);
        #1 data = bus_rdata;
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        wait_neg(3);
        rst_n = 1'b1;

        // R1: reset values.
        bus_read(KE, 0, rd); check("R1 enable lo", rd, '0);
        bus_read(KT, 1, rd); check("R1 type hi", rd, '0);
        bus_read(KP, 0, rd); check("R1 pol lo", rd, '0);
        bus_read(KB, 1, rd); check("R1 both hi", rd, '0);
        bus_read(KG, 0, rd); check("R1 global", rd, '0);
        bus_read(KM, 1, rd); check("R1 masked hi", rd, '0);
        check("R1 irq", {31'b0, irq}, '0);

        // R2: configuration read-back per bank.
        bus_write(KP, 1, 32'hA5A5_0F0F);
        bus_write(KE, 0, 32'h1234_5678);
        bus_read(KP, 1, rd); check("R2 pol hi readback", rd, 32'hA5A5_0F0F);
        bus_read(KP, 0, rd); check("R2 pol lo untouched", rd, '0);
        bus_read(KE, 0, rd); check("R2 enable lo readback", rd, 32'h1234_5678);
        bus_write(KE, 0, '0);
        bus_write(KG, 0, 32'h1);
        bus_read(KG, 0, rd); check("R2 global readback", rd, 32'h1);

        // Table walk over both banks.
        for (int i = 0; i < NV; i++) begin
            int b, h, bit_i;
            logic [DW-1:0] one;
            logic [5:0] v;
            v = VEC[i];
            b = (i*13 + 3) % N;
            h = b / DW;
            bit_i = b % DW;
            one = DW'(1) << bit_i;
            pad_in = '0; pad_in[b] = v[2];
            for (int hh = 0; hh < 2; hh++) begin
                bus_write(KT, hh, (hh == h && v[5]) ? one : '0);
                bus_write(KP, hh, (hh == h && v[4]) ? one : '0);
                bus_write(KB, hh, (hh == h && v[3]) ? one : '0);
            end
            wait_neg(4);
            bus_write(KC, 0, '1);
            bus_write(KC, 1, '1);
            @(negedge clk);
            pad_in[b] = v[1];
            wait_neg(3);
            bus_read(KS, h, rd);
            check($sformatf("R3/R4/R5 vector %0d", i), {31'b0, rd[bit_i]}, {31'b0, v[0]});
            if (!v[5]) begin
                bus_write(KC, h, one);
                bus_read(KS, h, rd);
                check($sformatf("R5 level after clear %0d", i), {31'b0, rd[bit_i]}, {31'b0, v[0]});
            end
        end

        // Edge mode, rising, on input 40 (bank 1 bit 8) for directed tests.
        pad_in = '0;
        bus_write(KT, 0, '0); bus_write(KP, 0, '0); bus_write(KB, 0, '0);
        bus_write(KT, 1, 32'h100); bus_write(KP, 1, 32'h100); bus_write(KB, 1, '0);
        wait_neg(4);
        bus_write(KC, 1, '1);

        // R10: latency through the synchronizer and edge detector.
        @(negedge clk);
        pad_in[40] = 1'b1;
        @(negedge clk); @(negedge clk);
        #1 bus_addr = 4'(KS*2 + 1);
        #1 check("R10 not yet after two edges", {31'b0, bus_rdata[8]}, '0);
        @(negedge clk);
        #1 check("R10 set after three edges", {31'b0, bus_rdata[8]}, 32'h1);

        // R8: masking and global gating.
        bus_read(KM, 1, rd); check("R8 masked while disabled", rd, '0);
        check("R8 irq low with enable off", {31'b0, irq}, '0);
        bus_write(KE, 1, 32'h100);
        bus_read(KM, 1, rd); check("R8 masked value", rd, 32'h100);
        check("R8 irq high", {31'b0, irq}, 32'h1);
        bus_write(KG, 0, '0);
        #1 check("R8 irq low with global off", {31'b0, irq}, '0);

        // R6: clearing with zeros keeps the bit, ones clears it.
        bus_write(KC, 1, 32'hFFFF_FEFF);
        bus_read(KS, 1, rd); check("R6 zero bit keeps status", {31'b0, rd[8]}, 32'h1);
        bus_write(KC, 1, 32'h100);
        bus_read(KS, 1, rd); check("R6 one bit clears status", {31'b0, rd[8]}, '0);

        // R9: no latching while global enable is off.
        pad_in[40] = 1'b0; wait_neg(4);
        pad_in[40] = 1'b1; wait_neg(4);
        bus_read(KS, 1, rd); check("R9 no latch while disabled", {31'b0, rd[8]}, '0);
        bus_write(KG, 0, 32'h1);

        // R7: an edge and a clear of the same bit in one cycle.
        bus_write(KB, 1, 32'h100);
        @(negedge clk);
        pad_in[40] = 1'b0;
        wait_neg(4);
        bus_read(KS, 1, rd); check("R4 both-edge fall latched", {31'b0, rd[8]}, 32'h1);
        @(negedge clk);
        pad_in[40] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(KC*2 + 1); bus_wdata = 32'h100;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_read(KS, 1, rd); check("R7 edge wins over clear", {31'b0, rd[8]}, 32'h1);
        bus_write(KC, 1, 32'h100);
        bus_read(KS, 1, rd); check("R7 later clear works", {31'b0, rd[8]}, '0);
        check("R8 irq low after clear", {31'b0, irq}, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule